// File: doc/BRIEF.md
# Integer Compare to Condition Field

This unit compares a 32-bit register operand against a second operand and records the outcome as a 4-bit code in one of eight fields of a 32-bit condition register. The second operand is either a second register value or a 16-bit immediate. A 2-bit kind selects between algebraic and unsigned-magnitude comparison, and between the register operand and the immediate. Signed kinds widen the immediate by sign extension. Unsigned kinds widen it with zeros.

Compare requests arrive on a valid/ready input. The unit accepts one compare per clock and never applies back-pressure, so `in_ready` stays high. A request counts as accepted on any rising edge where `in_valid` is high. An accepted request with a clear length bit writes its 4-bit code into the chosen field on that edge. No other field changes. An accepted request with the length bit set is illegal here: the unit raises `illegal` for one cycle and leaves the register untouched. The condition register and `illegal` are plain outputs that hold their value between updates.

Top module: `cmp_cond_unit`

## Requirements
- R1: After reset, `cond_reg` is all zeros, `illegal` is 0 and `in_ready` is 1.
- R2: Kind 2'b00 compares `opnd_a` with `opnd_b` as two's-complement numbers. `imm16` has no effect.
- R3: Kind 2'b01 compares `opnd_a` algebraically with `imm16` sign-extended to 32 bits. `opnd_b` has no effect.
- R4: Kind 2'b10 compares `opnd_a` with `opnd_b` as unsigned magnitudes. `imm16` has no effect.
- R5: Kind 2'b11 compares `opnd_a` as an unsigned magnitude with `imm16` zero-extended to 32 bits. `opnd_b` has no effect.
- R6: A written field holds {lt, gt, eq, so}, MSB first, and exactly one of lt, gt and eq is 1.
- R7: The so bit of a written field equals `so_flag` as sampled on the accepting edge.
- R8: Field k (k = 0..7, selected by `dest_field`) occupies `cond_reg[31-4k:28-4k]`. A legal accepted compare changes only that field.
- R9: On an edge without `in_valid`, `cond_reg` keeps its value and `illegal` is 0 in the following cycle.
- R10: An accepted request with `len_sel` = 1 leaves `cond_reg` unchanged and drives `illegal` to 1 for exactly the following cycle.
- R11: `in_ready` is 1 in every cycle out of reset, so the unit never stalls a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A compare request is present |
| in_ready | output | 1 | Unit can take a request (always 1) |
| cmp_kind | input | 2 | bit1: unsigned, bit0: immediate operand |
| len_sel | input | 1 | Length bit; must be 0 for a legal compare |
| dest_field | input | 3 | Index of the condition field to write |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Register second operand |
| imm16 | input | 16 | Immediate second operand |
| so_flag | input | 1 | Sticky summary-overflow flag to copy |
| cond_reg | output | 32 | Condition register, eight 4-bit fields |
| illegal | output | 1 | One-cycle pulse after an illegal request |

## Verification
The same pair of operand patterns is applied under each kind, so one sign-bit pattern tells apart the results the four kinds should give. For example, 0xFFFFFFFB against 3 must read "less" when signed and "greater" when unsigned. An immediate of 0x8000 shows whether sign or zero extension was applied, and a junk `opnd_b` or `imm16` exposes a path that reads the unused operand. Walking the destination through all eight fields with `so_flag` toggling detects misplaced slices and disturbed neighbours. Idle cycles, length-bit requests and a long randomized stream against the behavioural model cover holding, the illegal pulse and mixed sequences.

// File: rtl/cmpcr_pkg.sv
package cmpcr_pkg;

  typedef enum logic [1:0] {
    CK_SREG = 2'b00,
    CK_SIMM = 2'b01,
    CK_UREG = 2'b10,
    CK_UIMM = 2'b11
  } cmp_kind_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_nib_t;

  localparam int unsigned NIB_W = $bits(cond_nib_t);

endpackage

// File: rtl/cmpcr_operand.sv
module cmpcr_operand #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [1:0]        kind,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] opnd
);
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic              use_imm;
  logic              is_uns;
  logic              fill_bit;
  logic [DATA_W-1:0] imm_wide;

  assign use_imm  = kind[0];
  assign is_uns   = kind[1];
  assign fill_bit = imm[IMM_W-1] & ~is_uns;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_wide = {{EXT_W{fill_bit}}, imm};
    end else begin : g_noext
      assign imm_wide = imm[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    opnd = use_imm ? imm_wide : reg_b;
  end
endmodule

// File: rtl/cmpcr_magnitude.sv
module cmpcr_magnitude
  import cmpcr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_uns,
  input  logic              so_in,
  output cond_nib_t         nib
);
  logic signed [DATA_W:0] a_x;
  logic signed [DATA_W:0] b_x;
  logic                   less;
  logic                   same;

  always_comb begin
    a_x  = {a[DATA_W-1] & ~is_uns, a};
    b_x  = {b[DATA_W-1] & ~is_uns, b};
    less = (a_x < b_x);
    same = (a == b);
    nib.lt = less;
    nib.eq = same;
    nib.gt = ~less & ~same;
    nib.so = so_in;
  end
endmodule

// File: rtl/cmpcr_field_write.sv
module cmpcr_field_write #(
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned FIELD_W    = 4,
  localparam int unsigned IDX_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int unsigned CR_W      = NUM_FIELDS * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   idx,
  input  logic [FIELD_W-1:0] nib,
  output logic [CR_W-1:0]    cr
);
  generate
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
      logic [FIELD_W-1:0] q;
      logic               hit;

      assign hit = wr_en && (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (hit) begin
          q <= nib;
        end
      end

      assign cr[CR_W-1-g*FIELD_W -: FIELD_W] = q;
    end
  endgenerate
endmodule

// File: rtl/cmp_cond_unit.sv
module cmp_cond_unit
  import cmpcr_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IMM_W      = 16,
  parameter int unsigned NUM_FIELDS = 8,
  localparam int unsigned FIELD_W   = NIB_W,
  localparam int unsigned IDX_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int unsigned CR_W      = NUM_FIELDS * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        cmp_kind,
  input  logic              len_sel,
  input  logic [IDX_W-1:0]  dest_field,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm16,
  input  logic              so_flag,
  output logic [CR_W-1:0]   cond_reg,
  output logic              illegal
);
  logic [DATA_W-1:0] second;
  cond_nib_t         result;
  logic              accept;
  logic              do_write;
  logic              illegal_q;

  assign in_ready = 1'b1;
  assign accept   = in_valid & in_ready;
  assign do_write = accept & ~len_sel;

  cmpcr_operand #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_opnd (
    .kind  (cmp_kind),
    .reg_b (opnd_b),
    .imm   (imm16),
    .opnd  (second)
  );

  cmpcr_magnitude #(
    .DATA_W (DATA_W)
  ) u_cmp (
    .a      (opnd_a),
    .b      (second),
    .is_uns (cmp_kind[1]),
    .so_in  (so_flag),
    .nib    (result)
  );

  cmpcr_field_write #(
    .NUM_FIELDS (NUM_FIELDS),
    .FIELD_W    (FIELD_W)
  ) u_wr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (do_write),
    .idx   (dest_field),
    .nib   (result),
    .cr    (cond_reg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= accept & len_sel;
    end
  end

  assign illegal = illegal_q;
endmodule

// File: rtl/cmpcr_checker.sv
module cmpcr_checker #(
  parameter int unsigned NUM_FIELDS = 8,
  localparam int unsigned FIELD_W   = 4,
  localparam int unsigned IDX_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int unsigned CR_W      = NUM_FIELDS * FIELD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             len_sel,
  input logic [IDX_W-1:0] dest_field,
  input logic             so_flag,
  input logic [CR_W-1:0]  cond_reg,
  input logic             illegal
);
  logic                last_wr;
  logic [IDX_W-1:0]    last_dest;
  logic                last_so;
  logic [FIELD_W-1:0]  last_fld;
  logic [CR_W-1:0]     keep_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_wr   <= 1'b0;
      last_dest <= '0;
      last_so   <= 1'b0;
    end else begin
      last_wr   <= in_valid & ~len_sel;
      last_dest <= dest_field;
      last_so   <= so_flag;
    end
  end

  always_comb begin
    last_fld  = cond_reg[CR_W-1-int'(last_dest)*FIELD_W -: FIELD_W];
    keep_mask = '1;
    for (int k = 0; k < NUM_FIELDS; k++) begin
      if (IDX_W'(k) == last_dest) begin
        keep_mask[CR_W-1-k*FIELD_W -: FIELD_W] = '0;
      end
    end
  end

  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |-> ($countones(last_fld[3:1]) == 1));

  p_so_copied_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |-> (last_fld[0] == last_so));

  p_others_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |-> ((cond_reg & keep_mask) == ($past(cond_reg) & keep_mask)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(cond_reg) && !illegal));

  p_illegal_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && len_sel) |-> ($stable(cond_reg) && illegal));

  p_illegal_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(in_valid && len_sel));
endmodule

bind cmp_cond_unit cmpcr_checker #(
  .NUM_FIELDS (NUM_FIELDS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .len_sel    (len_sel),
  .dest_field (dest_field),
  .so_flag    (so_flag),
  .cond_reg   (cond_reg),
  .illegal    (illegal)
);

// File: tb/cmp_cond_unit_test.sv
`timescale 1ns/1ps
module cmp_cond_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  cmp_kind = 2'b00;
  logic        len_sel = 1'b0;
  logic [2:0]  dest_field = 3'd0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [15:0] imm16 = '0;
  logic        so_flag = 1'b0;
  logic [31:0] cond_reg;
  logic        illegal;

  int          n_checks = 0;
  int          n_errors = 0;
  logic [31:0] exp_cr = '0;
  logic        exp_ill = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cmp_cond_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cmp_kind(cmp_kind), .len_sel(len_sel), .dest_field(dest_field),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16), .so_flag(so_flag),
    .cond_reg(cond_reg), .illegal(illegal)
  );

  function automatic logic [3:0] ref_code(input logic [1:0] k, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] im,
                                          input logic so);
    longint va, vb;
    if (k[1]) begin
      va = longint'({32'd0, a});
      vb = k[0] ? longint'(im) : longint'({32'd0, b});
    end else begin
      va = longint'($signed(a));
      vb = k[0] ? longint'($signed(im)) : longint'($signed(b));
    end
    if (va < vb)      return {3'b100, so};
    else if (va > vb) return {3'b010, so};
    else              return {3'b001, so};
  endfunction

  task automatic check(input string tag);
    n_checks++;
    if (cond_reg !== exp_cr || illegal !== exp_ill || in_ready !== 1'b1) begin
      n_errors++;
      $display("FAIL %s: cond_reg=%h illegal=%b ready=%b expected cond_reg=%h illegal=%b ready=1",
               tag, cond_reg, illegal, in_ready, exp_cr, exp_ill);
    end
  endtask

  // one clock: model updates from the driven request, then outputs are compared
  task automatic step(input string tag, input logic v, input logic [1:0] k,
                      input logic ls, input logic [2:0] f, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] im, input logic so);
    in_valid = v; cmp_kind = k; len_sel = ls; dest_field = f;
    opnd_a = a; opnd_b = b; imm16 = im; so_flag = so;
    @(posedge clk);
    exp_ill = v && ls;
    if (v && !ls) exp_cr[31-4*f -: 4] = ref_code(k, a, b, im, so);
    #1;
    check(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R2 signed register compare, imm16 junk
    step("R2 lt", 1, 2'b00, 0, 3'd0, 32'hFFFF_FFFB, 32'd3, 16'h7FFF, 0);
    step("R2 gt", 1, 2'b00, 0, 3'd0, 32'd3, 32'hFFFF_FFFB, 16'h8000, 0);
    step("R2 eq", 1, 2'b00, 0, 3'd1, 32'h8000_0000, 32'h8000_0000, 16'h0001, 0);
    // R4 same patterns as unsigned
    step("R4 gt", 1, 2'b10, 0, 3'd2, 32'hFFFF_FFFB, 32'd3, 16'h0000, 0);
    step("R4 lt", 1, 2'b10, 0, 3'd2, 32'd3, 32'hFFFF_FFFB, 16'hFFFF, 0);
    // R3 sign-extended immediate, opnd_b junk
    step("R3 gt", 1, 2'b01, 0, 3'd3, 32'd0, 32'h0000_0000, 16'h8000, 0);
    step("R3 eq", 1, 2'b01, 0, 3'd3, 32'hFFFF_8000, 32'h1234_5678, 16'h8000, 0);
    // R5 zero-extended immediate
    step("R5 lt", 1, 2'b11, 0, 3'd4, 32'd0, 32'hFFFF_FFFF, 16'h8000, 0);
    step("R5 eq", 1, 2'b11, 0, 3'd4, 32'h0000_8000, 32'h0, 16'h8000, 0);
    step("R5 gt", 1, 2'b11, 0, 3'd5, 32'hFFFF_8000, 32'h0, 16'h8000, 0);
    // R7 summary overflow copied
    step("R7 so set", 1, 2'b00, 0, 3'd6, 32'd9, 32'd9, 16'h0, 1);
    step("R7 so clear", 1, 2'b00, 0, 3'd6, 32'd9, 32'd9, 16'h0, 0);
    // R8 walk every field, R6 one-of-three outcome
    for (int f = 0; f < 8; f++) begin
      step("R8 field walk", 1, 2'(f % 4), 0, 3'(f), 32'(f * 7), 32'd20, 16'd20, f[0]);
    end
    // R9 idle cycles with junk operands
    for (int i = 0; i < 4; i++) begin
      step("R9 idle", 0, 2'b01, 0, 3'(i), 32'hDEAD_BEEF, 32'h0, 16'h1, 1);
    end
    // R10 length bit set
    step("R10 illegal", 1, 2'b00, 1, 3'd0, 32'd1, 32'd2, 16'h0, 1);
    step("R10 pulse end", 0, 2'b00, 0, 3'd0, 32'd1, 32'd2, 16'h0, 0);
    step("R10 back to back a", 1, 2'b11, 1, 3'd7, 32'd5, 32'd5, 16'h5, 1);
    step("R10 back to back b", 1, 2'b11, 1, 3'd2, 32'd5, 32'd5, 16'h5, 0);
    step("R10 then legal", 1, 2'b10, 0, 3'd7, 32'd1, 32'd2, 16'h0, 1);
    // R11 and mixed stream
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = (i % 5 == 0) ? ra : $urandom();
      step("R11 R6 random", ($urandom() % 4) != 0, 2'($urandom()),
           ($urandom() % 8) == 0, 3'($urandom()), ra, rb,
           (i % 6 == 0) ? ra[15:0] : 16'($urandom()), 1'($urandom()));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule